// File: doc/BRIEF.md
# Port-Write Capture Unit

This block accepts inbound port-write maintenance packets from a link receiver and holds one of them in a single-entry capture buffer until a host frees it. Each packet arrives as a one-cycle valid strobe together with a fixed-size payload and an error flag. The host reaches the block through a small register bus. A mode register enables the unit, selects interrupt sources and issues the command that frees the buffer. A status register reports captures, drops, transaction errors and the buffer level. A separate word-indexed read port returns the captured payload. One level-sensitive interrupt output goes to the host.

Once a packet has been captured, the buffer stays occupied until the host writes the clear-queue command. Any good packet that arrives while the buffer is occupied is dropped, and the drop is flagged. A transaction error can only be cleared while the unit is disabled, so the host has to turn the unit off before it acknowledges an error.

Top module: `pwcap_unit`

## Requirements
- R1: After reset, the mode register reads 0, the status register reads 0 and `irq` is low. `reg_rdata` is 0 whenever `reg_rd` is low.
- R2: The mode register (`reg_sel`=0) stores enable at bit 0, error-interrupt enable at bit 5, capture-interrupt enable at bit 8 and snoop enable at bit 20. Bit 1 is the clear-queue command: it is self-clearing and always reads 0. All other bits read 0.
- R3: Suppose the unit is enabled and the entry is empty. A good packet (`pkt_valid`=1, `pkt_err`=0) is then stored, and word i of the payload (`pkt_payload[i*32 +: 32]`) reads back on `pl_data` when `pl_idx`=i. The packet also sets the level flag (status bit 20) and the capture-interrupt flag (status bit 4).
- R4: A good packet that arrives while the entry is full is dropped. The stored payload stays unchanged, and the discard flag (status bit 3) is set.
- R5: Writing mode bit 1 empties the entry, so status bit 20 clears. The next good packet is then accepted. The clear-queue command does not clear status bit 4.
- R6: While enable is 0, packets and error packets are ignored and set no status bit.
- R7: While the unit is enabled, a packet with `pkt_err`=1 sets the transaction-error flag (status bit 7) and is not captured.
- R8: Status bits 4 and 3 are cleared by writing 1 to them (`reg_sel`=1). Writing 0 has no effect. When a set and a clear of the same bit fall in the same cycle, the set wins.
- R9: Writing 1 to status bit 7 clears it only while enable is 0. While enable is 1 the write is ignored.
- R10: `irq` is high exactly when (bit 4 and capture-interrupt enable) or (bit 7 and error-interrupt enable).
- R11: The busy flag (status bit 2) is high for exactly the cycle after a packet is accepted.
- R12: A clear-queue write and a good packet in the same cycle while the entry is full result in the new packet being captured. No discard is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pkt_valid | input | 1 | One-cycle strobe for an inbound port-write |
| pkt_err | input | 1 | The strobed packet carries a transaction error |
| pkt_payload | input | 128 | Packet payload, word 0 in the low bits |
| reg_sel | input | 1 | Register select: 0 mode, 1 status |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, 0 when not reading |
| pl_idx | input | 2 | Payload word index |
| pl_data | output | 32 | Captured payload word |
| irq | output | 1 | Interrupt request |

## Verification
The bench goes after the cycle where a clear-queue write meets an incoming packet. A design that evaluates fullness before the release would wrongly drop that packet and raise the discard flag. It also tries to clear a transaction error while the unit is enabled. A design that ignores the enable gate would lose the error and drop `irq`. Other targets are packets sent while the unit is disabled, set-versus-clear collisions on the same status bit, and readback of the self-clearing command bit. Each of these shows up as a status word, payload word or interrupt level that differs from the model the bench keeps.

// File: rtl/pwcap_pkg.sv
// Package: bit positions of the mode and status registers and the
// decoded mode fields. The field positions are decoded by host software.
package pwcap_pkg;
    localparam int REG_W   = 32;
    // mode register fields
    localparam int M_EN    = 0;
    localparam int M_CLRQ  = 1;
    localparam int M_ERRIE = 5;
    localparam int M_CAPIE = 8;
    localparam int M_SNOOP = 20;
    // status register fields
    localparam int S_BUSY  = 2;
    localparam int S_DROP  = 3;
    localparam int S_CAPI  = 4;
    localparam int S_TERR  = 7;
    localparam int S_LEVEL = 20;

    typedef struct packed {
        logic snoop;
        logic cap_ie;
        logic err_ie;
        logic en;
    } mode_t;
endpackage

// File: rtl/pwcap_mode.sv
// Module: mode register. Holds the enable, interrupt enables and snoop
// bit. It turns a write of the clear-queue bit into a one-cycle pulse
// that is never stored.
// Assumes: wr_en is a single-cycle strobe already qualified by select.
module pwcap_mode
    import pwcap_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output mode_t            mode,
    output logic             clrq_pulse
);
    // Stores the persistent mode fields on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= '0;
        end else if (wr_en) begin
            mode.en     <= wdata[M_EN];
            mode.err_ie <= wdata[M_ERRIE];
            mode.cap_ie <= wdata[M_CAPIE];
            mode.snoop  <= wdata[M_SNOOP];
        end
    end

    // Clear-queue command: combinational pulse during the write cycle.
    always_comb clrq_pulse = wr_en & wdata[M_CLRQ];
endmodule

// File: rtl/pwcap_buf.sv
// Module: single-entry payload buffer with an occupancy flag.
// Assumes: take is only asserted when the entry is free or is being
// released in the same cycle; release alone empties the entry.
module pwcap_buf #(
    parameter int WORDS  = 4,
    parameter int WORD_W = 32,
    localparam int PL_W  = WORDS * WORD_W,
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              release_q,
    input  logic [PL_W-1:0]   payload,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              full,
    output logic [WORD_W-1:0] rd_word
);
    logic [WORD_W-1:0] words [WORDS];

    // Occupancy: a capture sets it, a release alone clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)         full <= 1'b0;
        else if (take)      full <= 1'b1;
        else if (release_q) full <= 1'b0;
    end

    // One storage word per payload slice.
    for (genvar g = 0; g < WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n)    words[g] <= '0;
            else if (take) words[g] <= payload[g*WORD_W +: WORD_W];
        end
    end

    // Read port: out-of-range index returns zero.
    always_comb rd_word = (int'(rd_idx) < WORDS) ? words[rd_idx] : '0;
endmodule

// File: rtl/pwcap_status.sv
// Module: status flags. Capture and drop flags are write-one-to-clear.
// The error flag clears only while the unit is disabled. A set beats a
// clear in the same cycle. Busy marks the cycle after a capture.
// Assumes: event inputs are already gated by the enable.
module pwcap_status
    import pwcap_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_evt,
    input  logic             drop_evt,
    input  logic             err_evt,
    input  logic             unit_en,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output logic             capi,
    output logic             drop,
    output logic             terr,
    output logic             busy
);
    logic clr_capi, clr_drop, clr_terr;

    // Decode the write-one-to-clear requests.
    always_comb begin
        clr_capi = wr_en & wdata[S_CAPI];
        clr_drop = wr_en & wdata[S_DROP];
        clr_terr = wr_en & wdata[S_TERR] & ~unit_en;
    end

    // Sticky flags with set priority, plus the one-cycle busy marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            capi <= 1'b0;
            drop <= 1'b0;
            terr <= 1'b0;
            busy <= 1'b0;
        end else begin
            capi <= cap_evt  | (capi & ~clr_capi);
            drop <= drop_evt | (drop & ~clr_drop);
            terr <= err_evt  | (terr & ~clr_terr);
            busy <= cap_evt;
        end
    end
endmodule

// File: rtl/pwcap_unit.sv
// Module: port-write capture unit top. It qualifies incoming packets
// against the enable and the buffer level, steers them to capture,
// drop or error, and muxes register reads. It also forms the interrupt.
// Assumes: one register access per cycle, with reg_sel picking the target.
module pwcap_unit
    import pwcap_pkg::*;
#(
    parameter int WORDS  = 4,
    parameter int WORD_W = 32,
    localparam int PL_W  = WORDS * WORD_W,
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_valid,
    input  logic              pkt_err,
    input  logic [PL_W-1:0]   pkt_payload,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [IDX_W-1:0]  pl_idx,
    output logic [WORD_W-1:0] pl_data,
    output logic              irq
);
    mode_t mode;
    logic  clrq, full;
    logic  good_pkt, cap_evt, drop_evt, err_evt;
    logic  st_capi, st_drop, st_terr, st_busy;
    logic  [REG_W-1:0] mode_word, stat_word;

    pwcap_mode u_mode (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr & ~reg_sel), .wdata(reg_wdata),
        .mode(mode), .clrq_pulse(clrq)
    );

    // Packet steering: a release in the same cycle frees the entry first.
    always_comb begin
        good_pkt = mode.en & pkt_valid & ~pkt_err;
        cap_evt  = good_pkt & (~full | clrq);
        drop_evt = good_pkt & full & ~clrq;
        err_evt  = mode.en & pkt_valid & pkt_err;
    end

    pwcap_buf #(.WORDS(WORDS), .WORD_W(WORD_W)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .take(cap_evt), .release_q(clrq),
        .payload(pkt_payload), .rd_idx(pl_idx),
        .full(full), .rd_word(pl_data)
    );

    pwcap_status u_stat (
        .clk(clk), .rst_n(rst_n),
        .cap_evt(cap_evt), .drop_evt(drop_evt), .err_evt(err_evt),
        .unit_en(mode.en),
        .wr_en(reg_wr & reg_sel), .wdata(reg_wdata),
        .capi(st_capi), .drop(st_drop), .terr(st_terr), .busy(st_busy)
    );

    // Assemble the register words; the command bit is never shown.
    always_comb begin
        mode_word          = '0;
        mode_word[M_EN]    = mode.en;
        mode_word[M_ERRIE] = mode.err_ie;
        mode_word[M_CAPIE] = mode.cap_ie;
        mode_word[M_SNOOP] = mode.snoop;
        stat_word          = '0;
        stat_word[S_BUSY]  = st_busy;
        stat_word[S_DROP]  = st_drop;
        stat_word[S_CAPI]  = st_capi;
        stat_word[S_TERR]  = st_terr;
        stat_word[S_LEVEL] = full;
    end

    // Read mux, zero outside a read strobe.
    always_comb reg_rdata = !reg_rd ? '0 : (reg_sel ? stat_word : mode_word);

    // Interrupt: enabled capture flag or enabled error flag.
    always_comb irq = (st_capi & mode.cap_ie) | (st_terr & mode.err_ie);
endmodule

// File: rtl/pwcap_unit_chk.sv
// Module: assertion checker for pwcap_unit, attached with bind.
module pwcap_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_rd,
    input logic        reg_sel,
    input logic [31:0] reg_rdata,
    input logic        en,
    input logic        cap_ie,
    input logic        err_ie,
    input logic        pkt_valid,
    input logic        pkt_err,
    input logic        full,
    input logic        clrq,
    input logic        capi,
    input logic        drop,
    input logic        terr,
    input logic        irq
);
    AST_CLRQ_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !reg_sel) |-> !reg_rdata[1]); // R2
    AST_FULL_RAISES_CAPI: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full) |-> capi); // R3
    AST_DROP_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (en && pkt_valid && !pkt_err && full && !clrq) |=> drop); // R4
    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !$rose(capi) && !$rose(drop) && !$rose(terr)); // R6
    AST_ERR_HELD_WHILE_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (en && terr) |=> terr); // R9
    AST_NO_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_ie && !err_ie) |-> !irq); // R10
endmodule

bind pwcap_unit pwcap_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n),
    .reg_rd(reg_rd), .reg_sel(reg_sel), .reg_rdata(reg_rdata),
    .en(mode.en), .cap_ie(mode.cap_ie), .err_ie(mode.err_ie),
    .pkt_valid(pkt_valid), .pkt_err(pkt_err),
    .full(full), .clrq(clrq),
    .capi(st_capi), .drop(st_drop), .terr(st_terr), .irq(irq)
);

// File: tb/sim_pwcap_unit.sv
// Bench: directed corner cases, then seeded random traffic, all checked
// against a bench-side model built from the requirements.
module sim_pwcap_unit;
    localparam int CLK_PERIOD = 10;
    localparam int WORDS = 4;
    localparam int PL_W  = WORDS * 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            pkt_valid = 1'b0, pkt_err = 1'b0;
    logic [PL_W-1:0] pkt_payload = '0;
    logic            reg_sel = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic [1:0]      pl_idx = '0;
    logic [31:0]     pl_data;
    logic            irq;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    // model state
    bit [31:0]     m_mode = 0;
    bit            m_full = 0, m_capi = 0, m_drop = 0, m_terr = 0, m_busy = 0;
    bit [PL_W-1:0] m_pl = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwcap_unit u0 (
        .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_err(pkt_err),
        .pkt_payload(pkt_payload), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pl_idx(pl_idx), .pl_data(pl_data), .irq(irq)
    );

    function automatic bit [31:0] exp_status();
        bit [31:0] s = 0;
        s[2] = m_busy; s[3] = m_drop; s[4] = m_capi; s[7] = m_terr; s[20] = m_full;
        return s;
    endfunction

    function automatic bit exp_irq();
        return (m_capi & m_mode[8]) | (m_terr & m_mode[5]);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Compare both registers, irq and every payload word against the model.
    task automatic check_all(input string req);
        reg_rd = 1'b1; reg_sel = 1'b0; #1;
        chk({req, " mode"}, reg_rdata, m_mode);
        reg_sel = 1'b1; #1;
        chk({req, " status"}, reg_rdata, exp_status());
        reg_rd = 1'b0; reg_sel = 1'b0; #1;
        chk({req, " irq"}, {31'b0, irq}, {31'b0, exp_irq()});
        for (int i = 0; i < WORDS; i++) begin
            pl_idx = 2'(i); #1;
            chk({req, " payload"}, pl_data, m_pl[i*32 +: 32]);
        end
    endtask

    // One clock of stimulus, with the model advanced alongside.
    task automatic step(input bit pv, input bit pe, input bit [PL_W-1:0] pl,
                        input bit mw, input bit sw, input bit [31:0] wd);
        bit en, cq, acc, drp, err;
        @(negedge clk);
        pkt_valid = pv; pkt_err = pe; pkt_payload = pl;
        reg_wr = mw | sw; reg_sel = sw; reg_wdata = wd;
        en  = m_mode[0];
        cq  = mw & wd[1];
        acc = en & pv & !pe & (!m_full | cq);
        drp = en & pv & !pe & m_full & !cq;
        err = en & pv & pe;
        @(posedge clk); #1;
        pkt_valid = 0; pkt_err = 0; reg_wr = 0; reg_sel = 0; reg_wdata = 0;
        m_capi = acc | (m_capi & !(sw & wd[4]));
        m_drop = drp | (m_drop & !(sw & wd[3]));
        m_terr = err | (m_terr & !(sw & wd[7] & !en));
        m_busy = acc;
        m_full = acc ? 1'b1 : (cq ? 1'b0 : m_full);
        if (acc) m_pl = pl;
        if (mw) m_mode = wd & 32'h0010_0121;
    endtask

    function automatic bit [PL_W-1:0] rnd_pl();
        bit [PL_W-1:0] p;
        for (int i = 0; i < WORDS; i++) p[i*32 +: 32] = $urandom;
        return p;
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        bit [PL_W-1:0] p1, p2;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state and idle read data
        chk("R1 rdata idle", reg_rdata, 0);
        check_all("R1");
        // R2: every bit written, only the four fields read back
        step(0, 0, '0, 1, 0, 32'hFFFF_FFFF);
        check_all("R2");
        step(0, 0, '0, 1, 0, 32'h0010_0123);
        check_all("R2 clrq self-clear");
        // R3: capture into the empty entry
        p1 = rnd_pl();
        step(1, 0, p1, 0, 0, 0);
        check_all("R3 R11 capture");
        step(0, 0, '0, 0, 0, 0);
        check_all("R11 busy drops");
        // R4: drop while full
        p2 = rnd_pl();
        step(1, 0, p2, 0, 0, 0);
        check_all("R4 drop");
        // R8: writing zeros does nothing, then ones clear
        step(0, 0, '0, 0, 1, 32'h0);
        check_all("R8 zero write");
        step(0, 0, '0, 0, 1, 32'h18);
        check_all("R8 w1c");
        // R8: a set and a clear in the same cycle, the set wins
        step(1, 0, rnd_pl(), 0, 1, 32'h08);
        check_all("R8 set wins");
        // R12: clear and packet in the same cycle
        step(1, 0, rnd_pl(), 1, 0, 32'h0000_0123);
        check_all("R12 clear with packet");
        // R5: release alone, then accept again
        step(0, 0, '0, 1, 0, 32'h0000_0123);
        check_all("R5 release");
        step(1, 0, rnd_pl(), 0, 0, 0);
        check_all("R5 reaccept");
        // R7, R10: error packet
        step(1, 1, rnd_pl(), 0, 0, 0);
        check_all("R7 R10 error");
        // R9: clear ignored while enabled, honoured once disabled
        step(0, 0, '0, 0, 1, 32'h80);
        check_all("R9 clear while on");
        step(0, 0, '0, 1, 0, 32'h0000_0020);
        step(0, 0, '0, 0, 1, 32'h80);
        check_all("R9 clear while off");
        // R6: disabled unit ignores everything
        step(0, 0, '0, 0, 1, 32'h9C);
        step(1, 0, rnd_pl(), 0, 0, 0);
        step(1, 1, rnd_pl(), 0, 0, 0);
        check_all("R6 disabled");
        // random traffic against the model
        for (int n = 0; n < 3000; n++) begin
            bit [31:0] r = $urandom;
            bit [31:0] wd = $urandom & 32'h0010_01BF;
            bit mw = (r[3:0] == 0), sw = (r[3:0] == 1);
            if (mw && r[4]) wd[0] = 1'b1;
            step(r[8] | r[9], r[10] & r[11] & r[12], rnd_pl(), mw, sw, wd);
            check_all("R2 R3 R4 R5 R7 R8 R9 R10 R11 R12 random");
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule